// File: doc/BRIEF.md
# Chunk Hamming Code Generator

The block computes a three-byte single-error-correcting Hamming code over a fixed chunk of 256 data bytes, the kind of code stored beside each chunk of a flash page. Bytes stream in one per clock, qualified by `valid_i`. A beat with `start_i` high opens a new chunk. When the 256th accepted byte of the chunk has been taken, the block drives the finished code on `code_o` and raises `done_o` for one cycle.

The code has two parts:

- **Column parity** tracks the parity of selected bit positions inside the bytes.
- **Line parity** tracks, for every bit of the byte index, whether the bytes with odd parity sit at indices where that bit is 0 or where it is 1.

The accumulated code is then inverted bitwise, and its two lowest bits are forced to 1. As a result, a chunk of all zeros gives `24'hFFFFFF`. A reader recomputes the code over the stored chunk and compares it with the stored code. A single flipped data bit changes exactly 11 code bits, and those bits locate the byte and the bit that flipped.

Top module: `chunk_ecc_gen`

## Requirements
- R1: Code byte 0 (`code_o[7:0]`) carries the column parity before inversion. Bit 2 is the XOR over the chunk of data bits 0,2,4,6 and bit 3 the XOR of bits 1,3,5,7. Bit 4 covers bits 0,1,4,5 and bit 5 covers bits 2,3,6,7. Bit 6 covers bits 0..3 and bit 7 covers bits 4..7.
- R2: Each byte whose 8-bit parity is odd toggles one bit per index bit k, at position 2k+index[k] of a 16-bit line vector. Line vector bits 7:0 form code byte 2 (`code_o[23:16]`) and bits 15:8 form code byte 1 (`code_o[15:8]`). Even-parity bytes leave the line vector unchanged.
- R3: The presented code is the bitwise inverse of the accumulated 24 bits, with `code_o[1:0]` forced to 2'b11.
- R4: `done_o` is high for exactly one cycle. That cycle is the one after the clock edge that accepts the 256th byte of a chunk.
- R5: `code_o` holds its value between completions.
- R6: Only cycles with `valid_i` high are counted and accumulated. Idle cycles inside a chunk have no effect on the result.
- R7: A beat with `start_i` and `valid_i` clears the accumulation and is byte 0 of the new chunk. Chunks may follow each other with no idle cycle.
- R8: A start beat inside an unfinished chunk discards that partial chunk without a `done_o`, and accumulation restarts from the start beat.
- R9: Valid bytes with `start_i` low while no chunk is open are ignored.
- R10: While `rst_ni` is low and after its release, `done_o` is 0 and `code_o` is 0 until the first chunk completes.
- R11: Two chunks that differ in exactly one data bit yield codes that differ in exactly 11 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte on `data_i` is valid this cycle |
| start_i | input | 1 | With `valid_i`, marks byte 0 of a chunk |
| data_i | input | 8 | Data byte |
| done_o | output | 1 | One-cycle pulse when the code is ready |
| code_o | output | 24 | Code bytes 2,1,0 from msb to lsb, held until the next completion |

## Verification
An all-zero chunk separates the inversion and forced bits from the parity logic. A single set byte at index 0 exercises one column pattern and the all-zero line half. Pseudo-random chunks are fed both with and without idle gaps; they are compared against an independent byte-wise model, and they show whether gaps leak into the count. Back-to-back chunks, a mid-chunk restart and stray bytes before a start distinguish clearing from holding. A one-bit flip must move exactly 11 code bits, which confirms the syndrome structure independently of the model.

// File: rtl/chunk_ecc_pkg.sv
package chunk_ecc_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned COL_W   = 6;
  localparam int unsigned LINE_W  = 16;
  localparam int unsigned CODE_W  = 24;
  localparam logic [1:0]  FORCE_LO = 2'b11;

  typedef struct packed {
    logic [7:0] byte2;
    logic [7:0] byte1;
    logic [7:0] byte0;
  } code_t;
endpackage

// File: rtl/chunk_ecc_col.sv
module chunk_ecc_col
  import chunk_ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [COL_W-1:0]  col_o,
  output logic              par_o
);
  localparam int unsigned LVL = COL_W / 2;

  // level j: even slot = bits with position bit j clear, odd slot = set
  for (genvar j = 0; j < LVL; j++) begin : g_lvl
    logic [DATA_W-1:0] sel_lo;
    logic [DATA_W-1:0] sel_hi;
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign sel_lo[i] = ((i >> j) & 1) == 0 ? data_i[i] : 1'b0;
      assign sel_hi[i] = ((i >> j) & 1) == 1 ? data_i[i] : 1'b0;
    end
    assign col_o[2*j]   = ^sel_lo;
    assign col_o[2*j+1] = ^sel_hi;
  end

  assign par_o = ^data_i;
endmodule

// File: rtl/chunk_ecc_line.sv
module chunk_ecc_line
  import chunk_ecc_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              par_i,
  output logic [LINE_W-1:0] line_o
);
  localparam int unsigned SLOTS = LINE_W / 2;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k < IDX_W) begin : g_used
      assign line_o[2*k]   = par_i & ~idx_i[k];
      assign line_o[2*k+1] = par_i &  idx_i[k];
    end else begin : g_pad
      assign line_o[2*k+1:2*k] = 2'b00;
    end
  end
endmodule

// File: rtl/chunk_ecc_seq.sv
module chunk_ecc_seq #(
  parameter int unsigned CHUNK_BYTES = 256,
  parameter int unsigned IDX_W       = $clog2(CHUNK_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             start_i,
  output logic             accept_o,
  output logic             first_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHUNK_BYTES - 1);

  logic             open_q;
  logic [IDX_W-1:0] idx_q;

  assign first_o  = valid_i & start_i;
  assign accept_o = valid_i & (start_i | open_q);
  assign idx_o    = first_o ? '0 : idx_q;
  assign last_o   = accept_o & (idx_o == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      idx_q  <= '0;
    end else if (accept_o) begin
      if (last_o) begin
        open_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        open_q <= 1'b1;
        idx_q  <= idx_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/chunk_ecc_gen.sv
module chunk_ecc_gen
  import chunk_ecc_pkg::*;
#(
  parameter int unsigned CHUNK_BYTES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned IDX_W = $clog2(CHUNK_BYTES);

  logic             accept, first, last;
  logic [IDX_W-1:0] idx;
  logic [COL_W-1:0] col;
  logic             par;
  logic [LINE_W-1:0] line;
  code_t            contrib, acc_q, acc_nxt, code_q;
  logic             done_q;

  chunk_ecc_seq #(.CHUNK_BYTES(CHUNK_BYTES), .IDX_W(IDX_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .start_i  (start_i),
    .accept_o (accept),
    .first_o  (first),
    .last_o   (last),
    .idx_o    (idx)
  );

  chunk_ecc_col u_col (
    .data_i (data_i),
    .col_o  (col),
    .par_o  (par)
  );

  chunk_ecc_line #(.IDX_W(IDX_W)) u_line (
    .idx_i  (idx),
    .par_i  (par),
    .line_o (line)
  );

  assign contrib.byte0 = {col, 2'b00};
  assign contrib.byte1 = line[15:8];
  assign contrib.byte2 = line[7:0];
  assign acc_nxt       = first ? contrib : (acc_q ^ contrib);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      code_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) acc_q <= acc_nxt;
      if (last) code_q <= ~acc_nxt | code_t'({22'd0, FORCE_LO});
    end
  end

  assign done_o = done_q;
  assign code_o = code_q;
endmodule

// File: rtl/chunk_ecc_chk.sv
module chunk_ecc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        done_o,
  input logic [23:0] code_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !done_o) |-> $stable(code_o)); // R5
  AST_FORCED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (code_o[1:0] == 2'b11)); // R3
  AST_DONE_AFTER_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && done_o) |-> $past(valid_i)); // R6
endmodule

bind chunk_ecc_gen chunk_ecc_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .done_o  (done_o),
  .code_o  (code_o)
);

// File: tb/chunk_ecc_gen_tb.sv
module chunk_ecc_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic        done_o;
  logic [23:0] code_o;

  int checks = 0;
  int errors = 0;
  logic [7:0]  mem [256];
  logic [31:0] lfsr = 32'hACE1_1234;

  chunk_ecc_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .start_i(start_i),
    .data_i(data_i), .done_o(done_o), .code_o(code_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // independent byte-wise reference model
  function automatic logic [23:0] model();
    logic [7:0] b0, b1, b2, d;
    b0 = 0; b1 = 0; b2 = 0;
    for (int i = 0; i < 256; i++) begin
      d = mem[i];
      b0[2] ^= d[0]^d[2]^d[4]^d[6];
      b0[3] ^= d[1]^d[3]^d[5]^d[7];
      b0[4] ^= d[0]^d[1]^d[4]^d[5];
      b0[5] ^= d[2]^d[3]^d[6]^d[7];
      b0[6] ^= d[0]^d[1]^d[2]^d[3];
      b0[7] ^= d[4]^d[5]^d[6]^d[7];
      if (^d) begin
        for (int k = 0; k < 4; k++) begin
          b2[2*k + ((i >> k) & 1)] ^= 1'b1;
          b1[2*k + ((i >> (k+4)) & 1)] ^= 1'b1;
        end
      end
    end
    b0 = ~b0 | 8'h03;
    return {~b2, ~b1, b0};
  endfunction

  function automatic logic [7:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31]^lfsr[21]^lfsr[1]^lfsr[0]};
    return lfsr[7:0];
  endfunction

  task automatic fill_rand();
    for (int i = 0; i < 256; i++) mem[i] = rnd();
  endtask

  // drive one chunk; gap inserts idle cycles; ends with valid low at a negedge after completion
  task automatic send_chunk(input bit gap, output logic [23:0] got, output logic done_seen);
    for (int i = 0; i < 256; i++) begin
      if (gap && (i % 3 == 1)) begin
        @(negedge clk_i); valid_i = 1'b0; start_i = 1'b0;
      end
      @(negedge clk_i);
      valid_i = 1'b1; start_i = (i == 0); data_i = mem[i];
    end
    @(negedge clk_i);
    valid_i = 1'b0; start_i = 1'b0;
    done_seen = done_o; got = code_o;
  endtask

  task automatic t_reset();
    check("R10 done in reset", {23'd0, done_o}, 24'd0);
    check("R10 code in reset", code_o, 24'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 code after reset", code_o, 24'd0);
  endtask

  task automatic t_zero();
    logic [23:0] c; logic d;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    send_chunk(1'b0, c, d);
    check("R4 done after zero chunk", {23'd0, d}, 24'd1);
    check("R3 zero chunk code", c, 24'hFFFFFF);
    @(negedge clk_i);
    check("R4 done one cycle", {23'd0, done_o}, 24'd0);
    check("R5 code held", code_o, 24'hFFFFFF);
  endtask

  task automatic t_single();
    logic [23:0] c; logic d;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[0] = 8'h01;
    send_chunk(1'b0, c, d);
    check("R1 R2 single byte code", c, model());
    check("R1 R2 single byte literal", c, 24'hAAAAAB);
    mem[0] = 8'h03; // even parity: line bits untouched
    send_chunk(1'b0, c, d);
    check("R2 even byte leaves line", c[23:8], 16'hFFFF);
    check("R1 even byte column", c, model());
  endtask

  task automatic t_random();
    logic [23:0] c; logic d;
    for (int r = 0; r < 3; r++) begin
      fill_rand();
      send_chunk(1'b0, c, d);
      check("R1 R2 random chunk", c, model());
    end
    fill_rand();
    send_chunk(1'b1, c, d);
    check("R6 gapped done", {23'd0, d}, 24'd1);
    check("R6 gapped chunk", c, model());
  endtask

  task automatic t_b2b();
    logic [23:0] e1;
    fill_rand(); e1 = model();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk_i); valid_i = 1'b1; start_i = (i == 0); data_i = mem[i];
    end
    fill_rand();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk_i);
      if (i == 0) begin
        check("R7 b2b first done", {23'd0, done_o}, 24'd1);
        check("R7 b2b first code", code_o, e1);
      end
      valid_i = 1'b1; start_i = (i == 0); data_i = mem[i];
    end
    @(negedge clk_i); valid_i = 1'b0; start_i = 1'b0;
    check("R7 b2b second done", {23'd0, done_o}, 24'd1);
    check("R7 b2b second code", code_o, model());
  endtask

  task automatic t_restart();
    logic [23:0] c, prev; logic d; int dn;
    prev = code_o; dn = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i); dn += done_o;
      valid_i = 1'b1; start_i = (i == 0); data_i = rnd();
    end
    @(negedge clk_i); dn += done_o; valid_i = 1'b0; start_i = 1'b0;
    check("R8 no done for partial", dn, 0);
    check("R8 code kept", code_o, prev);
    fill_rand();
    send_chunk(1'b0, c, d);
    check("R8 restarted chunk code", c, model());
  endtask

  task automatic t_stray();
    logic [23:0] c, prev; logic d; int dn;
    prev = code_o; dn = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i); dn += done_o;
      valid_i = 1'b1; start_i = 1'b0; data_i = rnd();
    end
    @(negedge clk_i); dn += done_o; valid_i = 1'b0;
    check("R9 stray bytes no done", dn, 0);
    check("R9 stray bytes code held", code_o, prev);
    fill_rand();
    send_chunk(1'b0, c, d);
    check("R9 chunk after stray", c, model());
  endtask

  task automatic t_flip();
    logic [23:0] a, b; logic d;
    fill_rand();
    send_chunk(1'b0, a, d);
    mem[8'hA5][3] = ~mem[8'hA5][3];
    send_chunk(1'b0, b, d);
    check("R11 one-bit flip distance", $countones(a ^ b), 11);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    t_zero();
    t_single();
    t_random();
    t_b2b();
    t_restart();
    t_stray();
    t_flip();
    repeat (3) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule